// File: doc/BRIEF.md
# Register-Programmed SPI Master Channel

This block is one SPI master lane controlled through six word-addressed registers on a simple synchronous read/write port. Software picks the serial clock rate as a power-of-two division of the block clock. It also picks the word length (4 to 32 bits), the clock polarity and phase, and whether a word moves data both ways, only in, or only out. It then loads the transmit register to launch a word. Each word is shifted out MSB first on `spi_mosi` while `spi_miso` is sampled. The received bits land right-aligned in the receive register.

Chip-select does not follow word activity. It is a level that software holds asserted through a config bit, so any number of words can share one select window. Two request lines let a DMA engine keep the data registers serviced, each enabled separately. In receive-only mode the channel keeps itself fed: every read of the receive register launches the next word with all-zero transmit data. Software ends the chain by switching to full-duplex before the last read.

Top module: `spi_chan_master`

## Requirements
- R1: The register word addresses are config=0, status=1, control=2, transmit=3, receive=4, system=5. After reset the config and control registers read 0, status reads 6, system reads 1, `spi_sclk` and `spi_cs` are 0, and both DMA requests are 0.
- R2: Config bits [5:2] hold an exponent e. While a word shifts, the period of `spi_sclk` is 2^e block clocks, and e=0 gives the same period as e=1.
- R3: Config bits [11:7] hold the word length minus one. Field values 0 to 2 select 4 bits. Words go out MSB first from the right-aligned transmit value, and received words read back right-aligned with the unused upper bits at zero.
- R4: Config bit 1 (polarity) sets the idle level of `spi_sclk`. With config bit 0 (phase) clear, MISO is sampled on the first edge of each bit; with it set, MISO is sampled on the second edge.
- R5: Config bits [13:12] = 0 select full-duplex. A write to the transmit register starts a word, and on completion status bit 0 (receive available) sets and the received word is readable. Reading the receive register clears status bit 0.
- R6: Config bits [13:12] = 1 select receive-only. A transmit write starts the first word. Each receive-register read made while this mode holds starts a further word that shifts out zeros. Once the field is back at 0, a read starts nothing.
- R7: Config bits [13:12] = 2 select transmit-only. Completed words leave status bit 0 clear and the receive register unchanged.
- R8: Config bit 20 forces chip-select active while set. With config bit 6 set the active level is low, otherwise high. The pin shows the opposite level when bit 20 is clear.
- R9: `dma_tx_req` is high when config bit 14 is set, the channel is enabled, the mode is not receive-only and the transmit register is empty. `dma_rx_req` is high when config bit 15 is set and status bit 0 is set.
- R10: Control bit 0 enables the channel. While it is clear, no clock edge is produced and a loaded transmit word stays pending.
- R11: Status bit 1 is set when the transmit register is empty. Status bit 2 is set when the shifter is idle with no word pending.
- R12: Writing 1 to system bit 0 returns all registers, flags and the shifter to their reset values within two cycles, after which system bit 0 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (receive read has side effects) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip-select level |
| dma_tx_req | output | 1 | Transmit service request |
| dma_rx_req | output | 1 | Receive service request |

## Verification
Several properties are checked on every cycle: the serial clock moves only on divider-qualified edges and rests at its polarity when idle, no edge is produced while the channel is disabled, and the bit count stays within the legal word length. The receive-available flag rises only after a completed word outside transmit-only mode, and a soft reset leaves the config and enable cleared. The bench scenarios alone can show that data bits land in the right order and alignment for each mode and length, and that the measured clock period tracks the exponent. They also show the receive-only chain of zero-filled words stopping after the mode switch, and the chip-select and DMA levels seen at the pins.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_W  = 4;
  localparam int LEN_W  = $clog2(WORD_W) + 1;
  localparam int HALF_W = (1 << EXP_W) - 1;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SYS  = 3'd5;

  typedef enum logic [1:0] {
    XM_DUPLEX = 2'd0,
    XM_RXONLY = 2'd1,
    XM_TXONLY = 2'd2,
    XM_RSVD   = 2'd3
  } xmode_e;

  typedef struct packed {
    logic        force_cs;
    logic        dma_rx_en;
    logic        dma_tx_en;
    xmode_e      mode;
    logic [4:0]  wlen_m1;
    logic        cs_low;
    logic [EXP_W-1:0] div_exp;
    logic        cpol;
    logic        cpha;
  } cfg_t;

  // Field placement is what software sees; keep decode and encode symmetric.
  function automatic cfg_t cfg_decode(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.cpha      = w[0];
    c.cpol      = w[1];
    c.div_exp   = w[5:2];
    c.cs_low    = w[6];
    c.wlen_m1   = w[11:7];
    c.mode      = xmode_e'(w[13:12]);
    c.dma_tx_en = w[14];
    c.dma_rx_en = w[15];
    c.force_cs  = w[20];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_encode(input cfg_t c);
    return {11'd0, c.force_cs, 4'd0, c.dma_rx_en, c.dma_tx_en, c.mode,
            c.wlen_m1, c.cs_low, c.div_exp, c.cpol, c.cpha};
  endfunction

  // Effective word length; field values below 3 are clamped to 4 bits.
  function automatic logic [LEN_W-1:0] word_len(input logic [4:0] m1);
    if (m1 < 5'd3) return LEN_W'(4);
    return LEN_W'(m1) + 1'b1;
  endfunction

  // Block clocks per half bit; exponent 0 is clamped to the exponent-1 rate.
  function automatic logic [HALF_W-1:0] half_cycles(input logic [EXP_W-1:0] e);
    logic [HALF_W-1:0] one;
    one = 1;
    if (e == '0) return one;
    return one << (e - 1'b1);
  endfunction

  function automatic logic [WORD_W-1:0] word_mask(input logic [LEN_W-1:0] len);
    return {WORD_W{1'b1}} >> (LEN_W'(WORD_W) - len);
  endfunction

  function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] d,
                                                  input logic [LEN_W-1:0] len);
    return d << (LEN_W'(WORD_W) - len);
  endfunction
endpackage

// File: rtl/spi_chan_divider.sv
module spi_chan_divider
  import spi_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [EXP_W-1:0] div_exp,
  output logic             tick
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] limit;

  assign limit = half_cycles(div_exp) - 1'b1;
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || tick)  cnt_q <= '0;
    else if (run)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_chan_shifter.sv
module spi_chan_shifter
  import spi_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              start,
  input  logic [WORD_W-1:0] start_data,
  input  logic [LEN_W-1:0]  len,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              lead_edge,
  output logic              trail_edge,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic [LEN_W-1:0]  bits_left
);
  logic              busy_q, sclk_q, mosi_q, phase_q, done_q;
  logic [WORD_W-1:0] tx_sh, rx_sh, loaded;
  logic [LEN_W-1:0]  bits_q;

  assign loaded     = align_msb(start_data, len);
  assign lead_edge  = busy_q && tick && !phase_q;
  assign trail_edge = busy_q && tick && phase_q;
  assign busy       = busy_q;
  assign sclk       = sclk_q;
  assign mosi       = mosi_q;
  assign word_done  = done_q;
  assign bits_left  = bits_q;
  assign rx_word    = rx_sh & word_mask(len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0; phase_q <= 1'b0;
      done_q <= 1'b0; tx_sh <= '0; rx_sh <= '0; bits_q <= '0;
    end else if (srst) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0; phase_q <= 1'b0;
      done_q <= 1'b0; tx_sh <= '0; rx_sh <= '0; bits_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        tx_sh   <= loaded;
        bits_q  <= len;
        phase_q <= 1'b0;
        busy_q  <= 1'b1;
        sclk_q  <= cpol;
        if (!cpha) mosi_q <= loaded[WORD_W-1];
      end else if (lead_edge) begin
        sclk_q  <= ~cpol;
        phase_q <= 1'b1;
        if (!cpha) begin
          rx_sh <= {rx_sh[WORD_W-2:0], miso};
        end else begin
          mosi_q <= tx_sh[WORD_W-1];
          tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
        end
      end else if (trail_edge) begin
        sclk_q  <= cpol;
        phase_q <= 1'b0;
        bits_q  <= bits_q - 1'b1;
        if (!cpha) begin
          mosi_q <= tx_sh[WORD_W-2];
          tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
        end else begin
          rx_sh <= {rx_sh[WORD_W-2:0], miso};
        end
        if (bits_q == LEN_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (!busy_q) begin
        sclk_q <= cpol;
      end
    end
  end
endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
  import spi_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              word_done,
  input  logic [WORD_W-1:0] rx_word,
  output cfg_t              cfg,
  output logic              chan_en,
  output logic              start,
  output logic [WORD_W-1:0] start_data,
  output logic              srst_pend,
  output logic              tx_empty,
  output logic              rx_avail,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  cfg_t              cfg_q;
  logic              en_q, tx_full, rx_full, auto_go, srst_q;
  logic [WORD_W-1:0] tx_buf, rx_buf;
  logic              wr_cfg, wr_ctrl, wr_txd, wr_sys, rd_rx, eot;

  assign wr_cfg  = bus_wr && (bus_addr == A_CFG);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_txd  = bus_wr && (bus_addr == A_TXD);
  assign wr_sys  = bus_wr && (bus_addr == A_SYS);
  assign rd_rx   = bus_rd && (bus_addr == A_RXD);

  assign start      = en_q && !busy && !srst_q && (tx_full || auto_go);
  assign start_data = tx_full ? tx_buf : '0;
  assign eot        = !busy && !tx_full && !auto_go;

  assign cfg        = cfg_q;
  assign chan_en    = en_q;
  assign srst_pend  = srst_q;
  assign tx_empty   = !tx_full;
  assign rx_avail   = rx_full;
  assign dma_tx_req = cfg_q.dma_tx_en && en_q && (cfg_q.mode != XM_RXONLY) && !tx_full;
  assign dma_rx_req = cfg_q.dma_rx_en && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; en_q <= 1'b0; tx_full <= 1'b0; rx_full <= 1'b0;
      auto_go <= 1'b0; srst_q <= 1'b0; tx_buf <= '0; rx_buf <= '0;
    end else if (srst_q) begin
      cfg_q <= '0; en_q <= 1'b0; tx_full <= 1'b0; rx_full <= 1'b0;
      auto_go <= 1'b0; srst_q <= 1'b0; tx_buf <= '0; rx_buf <= '0;
    end else begin
      if (wr_cfg)  cfg_q <= cfg_decode(bus_wdata);
      if (wr_ctrl) en_q  <= bus_wdata[0];
      if (start) begin
        tx_full <= 1'b0;
        auto_go <= 1'b0;
      end
      if (wr_txd) begin
        tx_buf  <= bus_wdata;
        tx_full <= 1'b1;
      end
      if (rd_rx) begin
        rx_full <= 1'b0;
        if (cfg_q.mode == XM_RXONLY && en_q) auto_go <= 1'b1;
      end
      if (word_done && cfg_q.mode != XM_TXONLY) begin
        rx_buf  <= rx_word;
        rx_full <= 1'b1;
      end
      if (wr_sys && bus_wdata[0]) srst_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CFG:   bus_rdata = cfg_encode(cfg_q);
      A_STAT:  bus_rdata = {29'd0, eot, !tx_full, rx_full};
      A_CTRL:  bus_rdata = {31'd0, en_q};
      A_TXD:   bus_rdata = tx_buf;
      A_RXD:   bus_rdata = rx_buf;
      A_SYS:   bus_rdata = {31'd0, !srst_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_chan_master.sv
module spi_chan_master
  import spi_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  cfg_t              cfg;
  logic              chan_en, start, srst_pend, tx_empty, rx_avail;
  logic              busy, tick, lead_edge, trail_edge, word_done;
  logic [WORD_W-1:0] start_data, rx_word, cfg_word;
  logic [LEN_W-1:0]  bits_left, len;
  logic [1:0]        mode;

  assign len      = word_len(cfg.wlen_m1);
  assign cfg_word = cfg_encode(cfg);
  assign mode     = cfg.mode;
  assign spi_cs   = cfg.force_cs ^ cfg.cs_low;

  spi_chan_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .word_done(word_done), .rx_word(rx_word),
    .cfg(cfg), .chan_en(chan_en), .start(start), .start_data(start_data),
    .srst_pend(srst_pend), .tx_empty(tx_empty), .rx_avail(rx_avail),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  spi_chan_divider u_div (
    .clk(clk), .rst_n(rst_n), .clr(start || srst_pend),
    .run(busy && chan_en), .div_exp(cfg.div_exp), .tick(tick)
  );

  spi_chan_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .srst(srst_pend), .start(start),
    .start_data(start_data), .len(len), .cpha(cfg.cpha), .cpol(cfg.cpol),
    .tick(tick), .miso(spi_miso), .busy(busy), .sclk(spi_sclk),
    .mosi(spi_mosi), .lead_edge(lead_edge), .trail_edge(trail_edge),
    .word_done(word_done), .rx_word(rx_word), .bits_left(bits_left)
  );
endmodule

// File: rtl/spi_chan_checks.sv
module spi_chan_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        sclk,
  input logic        cpol,
  input logic        lead_edge,
  input logic        trail_edge,
  input logic        chan_en,
  input logic        word_done,
  input logic        rx_avail,
  input logic        tx_empty,
  input logic [1:0]  mode,
  input logic [5:0]  bits_left,
  input logic        srst_pend,
  input logic [31:0] cfg_word
);
  AST_BITS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bits_left >= 6'd1 && bits_left <= 6'd32)); // R3

  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(lead_edge || trail_edge)) |-> $stable(sclk)); // R2

  AST_IDLE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol)); // R4

  AST_NO_EDGE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !(lead_edge || trail_edge)); // R10

  AST_DONE_AFTER_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(trail_edge)); // R5

  AST_RXS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_avail) |-> ($past(word_done) && $past(mode) != 2'd2)); // R7

  AST_TXS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_empty); // R11

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pend |=> (cfg_word == 32'd0 && !chan_en && !srst_pend && !busy)); // R12
endmodule

bind spi_chan_master spi_chan_checks i_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(spi_sclk), .cpol(cfg.cpol),
  .lead_edge(lead_edge), .trail_edge(trail_edge), .chan_en(chan_en),
  .word_done(word_done), .rx_avail(rx_avail), .tx_empty(tx_empty),
  .mode(mode), .bits_left(bits_left), .srst_pend(srst_pend), .cfg_word(cfg_word)
);

// File: tb/test_spi_chan_master.sv
module test_spi_chan_master;
  import spi_chan_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs, dma_tx_req, dma_rx_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_chan_master i_spi_chan_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs(spi_cs), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  // ---------------- slave model ----------------
  logic        tb_cpha = 0, tb_cpol = 0, tb_cslow = 1;
  logic [31:0] slave_word = '0;
  int          tb_len = 8;
  int          k_base = 0;
  int          slv_k = 0;
  logic [31:0] slv_rx = '0;
  int          cyc = 0, last_lead = 0, lead_gap = 0;
  logic        sclk_prev = 0;
  int          miso_idx;
  logic        cs_act;

  always @(posedge clk) cyc <= cyc + 1;

  assign cs_act   = tb_cslow ? !spi_cs : spi_cs;
  assign miso_idx = slv_k - k_base;
  assign spi_miso = (miso_idx >= 0 && miso_idx < tb_len) ? slave_word[tb_len-1-miso_idx] : 1'b0;

  always @(negedge clk) begin
    if (spi_sclk !== sclk_prev && cs_act) begin
      if (spi_sclk != tb_cpol) begin
        lead_gap  <= cyc - last_lead;
        last_lead <= cyc;
      end
      if ((spi_sclk != tb_cpol) != tb_cpha) begin
        slv_rx <= {slv_rx[30:0], spi_mosi};
        slv_k  <= slv_k + 1;
      end
    end
    sclk_prev <= spi_sclk;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_stat(input int bitpos);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 20000; i++) begin
      rd(A_STAT, s);
      if (s[bitpos]) break;
    end
  endtask

  function automatic logic [31:0] mk_cfg(input logic cpha, cpol, input int e, input logic cslow,
                                         input int fld, input int mode, input logic dmaw, dmar, frc);
    return cpha + 2*cpol + 4*e + 64*cslow + 128*fld + 4096*mode
           + 16384*dmaw + 32768*dmar + (1 << 20)*frc;
  endfunction

  function automatic logic [31:0] len_mask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
  endfunction

  localparam logic [31:0] FRC = 32'h0010_0000;

  task automatic xfer(input logic cpha, cpol, input int e, input int fld,
                      input logic [31:0] txw, slvw, input string tag);
    logic [31:0] cw, r, m;
    int len;
    len = (fld < 3) ? 4 : fld + 1;
    m = len_mask(len);
    tb_cpha = cpha; tb_cpol = cpol; tb_cslow = 1;
    cw = mk_cfg(cpha, cpol, e, 1'b1, fld, 0, 0, 0, 0);
    wr(A_CFG, cw);
    wr(A_CTRL, 32'd1);
    slave_word = slvw; tb_len = len; k_base = slv_k;
    wr(A_CFG, cw | FRC);
    wr(A_TXD, txw);
    wait_stat(2);
    rd(A_RXD, r);
    wr(A_CFG, cw);
    check({tag, " R3 R5 received word"}, r, slvw & m);
    check({tag, " R3 R4 bits seen by slave"}, slv_rx & m, txw & m);
    check({tag, " R2 sclk period"}, lead_gap, (e == 0) ? 2 : (1 << e));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] r, cw;
    int base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sclk", spi_sclk, 0);
    check("R1 cs", spi_cs, 0);
    check("R1 dma", {dma_tx_req, dma_rx_req}, 0);
    rd(A_CFG, r);  check("R1 config", r, 0);
    rd(A_STAT, r); check("R1 R11 status", r, 6);
    rd(A_SYS, r);  check("R1 system", r, 1);
    rd(A_CTRL, r); check("R1 control", r, 0);

    // directed words
    xfer(0, 0, 1, 7,  32'h0000_00A5, 32'h0000_003C, "mode0 len8");
    xfer(1, 1, 0, 31, 32'hDEAD_BEEF, 32'h1234_5678, "mode3 len32 e0");
    xfer(0, 1, 3, 1,  32'h0000_000B, 32'h0000_0006, "field1 len4");
    xfer(1, 0, 2, 15, 32'hFFFF_9A5C, 32'hABCD_C35A, "mode1 len16");

    // random words
    for (int i = 0; i < 10; i++) begin
      xfer(1'($urandom), 1'($urandom), int'($urandom % 5), 3 + int'($urandom % 29),
           $urandom, $urandom, "random");
    end

    // R4 idle level follows polarity
    wr(A_CFG, mk_cfg(0, 1, 1, 1, 7, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    check("R4 idle sclk cpol1", spi_sclk, 1);
    wr(A_CFG, mk_cfg(0, 0, 1, 1, 7, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    check("R4 idle sclk cpol0", spi_sclk, 0);

    // R6 receive-only chain
    tb_cpha = 0; tb_cpol = 0; tb_cslow = 1;
    cw = mk_cfg(0, 0, 2, 1, 7, 1, 0, 0, 0);
    wr(A_CFG, cw);
    wr(A_CFG, cw | FRC);
    slave_word = 32'h5A; tb_len = 8; k_base = slv_k;
    wr(A_TXD, 32'h3C);
    wait_stat(0);
    check("R6 first word sends written data", slv_rx & 32'hFF, 32'h3C);
    rd(A_RXD, r);
    slave_word = 32'hC3; k_base = slv_k;
    check("R6 first received", r, 32'h5A);
    wait_stat(0);
    check("R6 auto word sends zeros", slv_rx & 32'hFF, 32'h00);
    base = slv_k;
    wr(A_CFG, mk_cfg(0, 0, 2, 1, 7, 0, 0, 0, 1));
    rd(A_RXD, r);
    check("R6 second received", r, 32'hC3);
    repeat (100) @(negedge clk);
    rd(A_STAT, r);
    check("R6 no word after mode switch status", r, 6);
    check("R6 no edges after mode switch", slv_k - base, 0);

    // R7 transmit-only
    slave_word = 32'hFF; k_base = slv_k;
    cw = mk_cfg(0, 0, 2, 1, 7, 2, 0, 0, 0);
    wr(A_CFG, cw | FRC);
    wr(A_TXD, 32'h96);
    wait_stat(2);
    rd(A_STAT, r);
    check("R7 receive flag stays clear", r & 1, 0);
    rd(A_RXD, r);
    check("R7 receive register unchanged", r, 32'hC3);
    check("R7 word was sent", slv_rx & 32'hFF, 32'h96);
    wr(A_CFG, cw);

    // R8 chip-select levels
    wr(A_CFG, mk_cfg(0, 0, 1, 1, 7, 0, 0, 0, 1));
    check("R8 forced active-low", spi_cs, 0);
    wr(A_CFG, mk_cfg(0, 0, 1, 0, 7, 0, 0, 0, 1));
    check("R8 forced active-high", spi_cs, 1);
    wr(A_CFG, mk_cfg(0, 0, 1, 1, 7, 0, 0, 0, 0));
    check("R8 released active-low", spi_cs, 1);

    // R9 R10 DMA and enable
    tb_cslow = 1;
    base = slv_k;
    wr(A_CFG, mk_cfg(0, 0, 1, 1, 7, 0, 1, 1, 0));
    wr(A_CTRL, 32'd1);
    check("R9 tx request when empty", dma_tx_req, 1);
    check("R9 rx request idle", dma_rx_req, 0);
    wr(A_CFG, mk_cfg(0, 0, 1, 1, 7, 1, 1, 1, 0));
    check("R9 tx request gated in receive-only", dma_tx_req, 0);
    wr(A_CFG, mk_cfg(0, 0, 1, 1, 7, 0, 1, 1, 0));
    wr(A_CTRL, 32'd0);
    check("R9 tx request gated by enable", dma_tx_req, 0);
    wr(A_TXD, 32'h11);
    repeat (30) @(negedge clk);
    rd(A_STAT, r);
    check("R10 R11 word pending while disabled", r, 0);
    check("R10 sclk idle while disabled", spi_sclk, 0);
    wr(A_CTRL, 32'd1);
    wait_stat(2);
    check("R9 rx request on receive", dma_rx_req, 1);
    rd(A_RXD, r);
    check("R9 rx request cleared by read", dma_rx_req, 0);
    rd(A_STAT, r);
    check("R5 R11 status after read", r, 6);

    // R12 soft reset
    wr(A_CFG, mk_cfg(1, 1, 3, 1, 9, 2, 1, 1, 1));
    wr(A_CTRL, 32'd1);
    wr(A_TXD, 32'h77);
    wr(A_SYS, 32'd1);
    rd(A_SYS, r);  check("R12 reset done", r, 1);
    rd(A_CFG, r);  check("R12 config cleared", r, 0);
    rd(A_CTRL, r); check("R12 control cleared", r, 0);
    rd(A_STAT, r); check("R12 status restored", r, 6);
    rd(A_TXD, r);  check("R12 transmit cleared", r, 0);
    check("R12 pins restored", {spi_sclk, spi_cs, dma_tx_req, dma_rx_req}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule